// File: doc/BRIEF.md
# Loudest Talker Channel Selector

This block picks one speaker out of several parallel audio channels and sends that speaker's samples to every output lane, as needed by a conference bridge. Each beat of `in_valid` delivers one signed sample per channel. The block groups accepted beats into frames of `FRAME_LEN` beats. For each frame it measures every channel's loudness as the sum of absolute sample values.

At each frame boundary the loudest enabled channel scores one win. A channel takes over the broadcast only when its win count reaches `WIN_THRESHOLD`. A brief noise burst or a spike therefore does not steal the floor. The channels that lose keep their counts. The `ch_en` mask removes unused inputs from the contest.

The selection made from one frame takes effect from the first sample of the next frame. The outputs are registered and follow the inputs one clock after capture.

Top module: `loudest_talker_sel`

## Requirements
- R1: A channel's frame level is the sum of the absolute values of its samples over exactly FRAME_LEN (default 64) beats with `in_valid` high. Cycles with `in_valid` low add nothing and do not advance the frame.
- R2: The absolute value of the most negative sample (-32768 for 16-bit samples) saturates to the largest positive value (32767). The level accumulator is wide enough that a full frame never overflows.
- R3: At each frame end, only the win counter of the loudest enabled channel increments. The counters of the losing channels keep their values across frames.
- R4: When the winning channel's counter reaches WIN_THRESHOLD (default 10), that channel becomes the selected channel and its counter returns to zero. Below the threshold, the selection does not change.
- R5: When levels are equal, the lowest-numbered channel wins.
- R6: A channel whose `ch_en` bit (bit n = channel n) is 0 never wins. With `ch_en` all zero, no counter changes and the selection stays put. A newly selected channel is always one that was enabled at the decision.
- R7: `out_valid` rises exactly one cycle after a captured beat. When `out_valid` is high, every output lane (lane n = bits n*SAMPLE_W upward) carries the selected channel's sample from that beat.
- R8: The selection decided from frame k first applies to the first sample of frame k+1. The last sample of frame k is still routed by the previous selection. `sel_ch` changes only at a frame decision.
- R9: After synchronous reset, `sel_ch` is 0, all win counters and the frame position are cleared, `out_valid` is 0 and `out_samples` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A beat of samples is present |
| in_samples | input | NUM_CH*SAMPLE_W | One signed sample per channel; channel n at bits n*SAMPLE_W upward |
| ch_en | input | NUM_CH | Channel participation mask, bit n = channel n |
| out_valid | output | 1 | Output beat valid |
| out_samples | output | NUM_CH*SAMPLE_W | Selected channel's sample copied onto every lane |
| sel_ch | output | $clog2(NUM_CH) | Index of the currently broadcast channel |

## Verification
The checker watches several properties on every cycle. It checks the one-cycle valid lag and that all output lanes are equal. It checks that each output sample comes from the channel selected at that moment. It also checks that a selection change occurs only right after a frame end, lands on an enabled channel, and that the reset state holds. Some behaviours depend on the history of many frames, and only the bench's frame sequences can show them. These are the levels being summed correctly, the saturation of the most negative sample, hysteresis that counts wins up to the threshold, losing channels keeping their counts, the tie rule, masked channels being ignored, and counters being cleared by reset.

// File: rtl/lts_pkg.sv
package lts_pkg;
  localparam int unsigned LTS_DEF_CH     = 4;
  localparam int unsigned LTS_DEF_SMP_W  = 16;
  localparam int unsigned LTS_DEF_FRAME  = 64;
  localparam int unsigned LTS_DEF_THRESH = 10;
endpackage

// File: rtl/lts_level_acc.sv
// Per-channel magnitude accumulator; snapshots the frame level at the frame's last beat.
module lts_level_acc #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned ACC_W    = 23
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step,
  input  logic                       last,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic        [ACC_W-1:0]    level
);
  localparam int unsigned MAG_W = SAMPLE_W - 1;
  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  logic [MAG_W-1:0] mag;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;

  always_comb begin
    if (sample == MOST_NEG) begin
      mag = {MAG_W{1'b1}};                 // saturate |min| to max positive
    end else if (sample[SAMPLE_W-1]) begin
      mag = MAG_W'(-sample);
    end else begin
      mag = sample[MAG_W-1:0];
    end
    acc_sum = acc_q + ACC_W'(mag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      level <= '0;
    end else if (step) begin
      if (last) begin
        level <= acc_sum;
        acc_q <= '0;
      end else begin
        acc_q <= acc_sum;
      end
    end
  end
endmodule

// File: rtl/lts_argmax.sv
// Finds the loudest enabled channel; strict compare keeps the lowest index on ties.
module lts_argmax #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ACC_W  = 23,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [NUM_CH*ACC_W-1:0] levels,
  input  logic [NUM_CH-1:0]       en,
  output logic                    win_any,
  output logic [IDX_W-1:0]        win_idx
);
  logic [ACC_W-1:0] best;

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int c = 0; c < int'(NUM_CH); c++) begin
      if (en[c] && (!win_any || levels[c*ACC_W +: ACC_W] > best)) begin
        win_any = 1'b1;
        win_idx = IDX_W'(c);
        best    = levels[c*ACC_W +: ACC_W];
      end
    end
  end
endmodule

// File: rtl/lts_win_ctrl.sv
// Per-channel win counters with threshold hysteresis; owns the selection register.
module lts_win_ctrl #(
  parameter int unsigned NUM_CH        = 4,
  parameter int unsigned WIN_THRESHOLD = 10,
  parameter int unsigned IDX_W         = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             decide,
  input  logic             win_any,
  input  logic [IDX_W-1:0] win_idx,
  output logic [IDX_W-1:0] sel
);
  localparam int unsigned CNT_W = $clog2(WIN_THRESHOLD + 1);
  localparam logic [CNT_W-1:0] THR = CNT_W'(WIN_THRESHOLD);

  logic [NUM_CH-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < int'(NUM_CH); g++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_inc;
      logic             mine;
      assign mine    = decide && win_any && (win_idx == IDX_W'(g));
      assign cnt_inc = cnt_q + 1'b1;
      assign hit[g]  = mine && (cnt_inc == THR);
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (mine) begin
          cnt_q <= (cnt_inc == THR) ? '0 : cnt_inc;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (|hit) begin
      sel <= win_idx;
    end
  end
endmodule

// File: rtl/loudest_talker_sel.sv
module loudest_talker_sel
  import lts_pkg::*;
#(
  parameter int unsigned NUM_CH        = LTS_DEF_CH,
  parameter int unsigned SAMPLE_W      = LTS_DEF_SMP_W,
  parameter int unsigned FRAME_LEN     = LTS_DEF_FRAME,
  parameter int unsigned WIN_THRESHOLD = LTS_DEF_THRESH,
  localparam int unsigned IDX_W        = $clog2(NUM_CH),
  localparam int unsigned LANES_W      = NUM_CH * SAMPLE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [LANES_W-1:0] in_samples,
  input  logic [NUM_CH-1:0]  ch_en,
  output logic               out_valid,
  output logic [LANES_W-1:0] out_samples,
  output logic [IDX_W-1:0]   sel_ch
);
  localparam int unsigned ACC_W = SAMPLE_W + $clog2(FRAME_LEN) + 1;
  localparam int unsigned POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0]        pos_q;
  logic                    frame_last;
  logic                    frame_done;
  logic [NUM_CH*ACC_W-1:0] levels;
  logic                    win_any;
  logic [IDX_W-1:0]        win_idx;
  logic [LANES_W-1:0]      cap_q;
  logic                    cap_vld_q;
  logic [SAMPLE_W-1:0]     pick;

  assign frame_last = (pos_q == POS_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= in_valid && frame_last;
      if (in_valid) begin
        pos_q <= frame_last ? '0 : pos_q + 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < int'(NUM_CH); g++) begin : g_lvl
      lts_level_acc #(
        .SAMPLE_W (SAMPLE_W),
        .ACC_W    (ACC_W)
      ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .step   (in_valid),
        .last   (frame_last),
        .sample (in_samples[g*SAMPLE_W +: SAMPLE_W]),
        .level  (levels[g*ACC_W +: ACC_W])
      );
    end
  endgenerate

  lts_argmax #(
    .NUM_CH (NUM_CH),
    .ACC_W  (ACC_W),
    .IDX_W  (IDX_W)
  ) u_argmax (
    .levels  (levels),
    .en      (ch_en),
    .win_any (win_any),
    .win_idx (win_idx)
  );

  lts_win_ctrl #(
    .NUM_CH        (NUM_CH),
    .WIN_THRESHOLD (WIN_THRESHOLD),
    .IDX_W         (IDX_W)
  ) u_win (
    .clk     (clk),
    .rst     (rst),
    .decide  (frame_done),
    .win_any (win_any),
    .win_idx (win_idx),
    .sel     (sel_ch)
  );

  // capture stage aligns samples with the decision made one cycle after a frame end
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q     <= '0;
      cap_vld_q <= 1'b0;
    end else begin
      cap_q     <= in_samples;
      cap_vld_q <= in_valid;
    end
  end

  assign pick = cap_q[sel_ch*SAMPLE_W +: SAMPLE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_samples <= '0;
    end else begin
      out_valid   <= cap_vld_q;
      out_samples <= {NUM_CH{pick}};
    end
  end
endmodule

// File: rtl/lts_checker.sv
module lts_checker #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned IDX_W    = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [NUM_CH*SAMPLE_W-1:0] in_samples,
  input logic [NUM_CH-1:0]          ch_en,
  input logic                       out_valid,
  input logic [NUM_CH*SAMPLE_W-1:0] out_samples,
  input logic [IDX_W-1:0]           sel_ch,
  input logic                       frame_done
);
  logic [NUM_CH*SAMPLE_W-1:0] in_q1, in_q2;
  logic [IDX_W-1:0]           sel_q;
  logic [NUM_CH-1:0]          en_q;
  logic                       lanes_same;

  always_ff @(posedge clk) begin
    in_q1 <= in_samples;
    in_q2 <= in_q1;
    sel_q <= sel_ch;
    en_q  <= ch_en;
  end

  always_comb begin
    lanes_same = 1'b1;
    for (int c = 1; c < int'(NUM_CH); c++) begin
      if (out_samples[c*SAMPLE_W +: SAMPLE_W] != out_samples[SAMPLE_W-1:0]) lanes_same = 1'b0;
    end
  end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst) in_valid |-> ##2 out_valid); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |-> ##2 !out_valid); // R7
  AST_LANES_EQUAL: assert property (@(posedge clk) disable iff (rst) out_valid |-> lanes_same); // R7
  AST_OUT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_samples[SAMPLE_W-1:0] == in_q2[sel_q*SAMPLE_W +: SAMPLE_W]); // R8
  AST_SEL_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(sel_ch)); // R8
  AST_SEL_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (frame_done && ch_en == '0) |=> $stable(sel_ch)); // R6
  AST_NEW_SEL_WAS_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (sel_ch != sel_q) |-> en_q[sel_ch]); // R6
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && sel_ch == '0 && out_samples == '0)); // R9
endmodule

bind loudest_talker_sel lts_checker #(
  .NUM_CH   (NUM_CH),
  .SAMPLE_W (SAMPLE_W),
  .IDX_W    (IDX_W)
) u_lts_checker (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_samples  (in_samples),
  .ch_en       (ch_en),
  .out_valid   (out_valid),
  .out_samples (out_samples),
  .sel_ch      (sel_ch),
  .frame_done  (frame_done)
);

// File: tb/test_loudest_talker_sel.sv
`timescale 1ns/1ps
module test_loudest_talker_sel;
  localparam int NCH = 4;
  localparam int SW  = 16;
  localparam int FL  = 64;

  typedef struct packed {
    logic [SW-1:0] s0, s1, s2, s3;
    logic [3:0]    en;
    logic [7:0]    nf;
    logic [1:0]    exp_sel;
  } vec_t;

  // each row: constant per-channel samples, enable mask, frame count, selection expected after the last frame
  localparam int NV = 10;
  localparam vec_t TV [NV] = '{
    '{16'd10,    16'd100, 16'd10,     16'd10,  4'hF, 8'd9,  2'd0}, // R4 below threshold
    '{16'd10,    16'd100, 16'd10,     16'd10,  4'hF, 8'd1,  2'd1}, // R4 reaches threshold
    '{16'd10,    16'd10,  -16'sd100,  16'd10,  4'hF, 8'd5,  2'd1}, // R1 negative samples
    '{16'd10,    16'd10,  16'd10,     16'd100, 4'hF, 8'd4,  2'd1}, // R3
    '{16'd10,    16'd10,  -16'sd100,  16'd10,  4'hF, 8'd5,  2'd2}, // R3 losing count kept
    '{16'd50,    16'd10,  16'd10,     16'd50,  4'hF, 8'd6,  2'd2}, // R5 tie
    '{16'd50,    16'd10,  16'd10,     16'd50,  4'hF, 8'd4,  2'd0}, // R5 lowest wins
    '{16'd10,    16'd60,  16'd20,     16'd200, 4'h7, 8'd6,  2'd0}, // R6 masked loudest
    '{16'd10,    16'd60,  16'd20,     16'd200, 4'h7, 8'd4,  2'd1}, // R6
    '{16'd32767, 16'd0,   -16'sd32768, 16'd0,  4'hF, 8'd10, 2'd0}  // R2 saturation tie
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic [NCH*SW-1:0] in_samples;
  logic [NCH-1:0]    ch_en;
  logic              out_valid;
  logic [NCH*SW-1:0] out_samples;
  logic [1:0]        sel_ch;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  loudest_talker_sel i_loudest_talker_sel (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_samples  (in_samples),
    .ch_en       (ch_en),
    .out_valid   (out_valid),
    .out_samples (out_samples),
    .sel_ch      (sel_ch)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_bcast(input string req, input logic [SW-1:0] exp);
    for (int c = 0; c < NCH; c++) check(req, out_samples[c*SW +: SW], exp);
  endtask

  // drives one frame; returns at the negedge after the last sample has reached the outputs
  task automatic run_frame(input logic [NCH*SW-1:0] smp, input logic [3:0] en, input bit gap);
    for (int i = 0; i < FL; i++) begin
      @(negedge clk);
      in_valid   = 1'b1;
      in_samples = smp;
      ch_en      = en;
      if (gap) begin
        @(negedge clk);
        in_valid   = 1'b0;
        in_samples = '0;
      end
    end
    if (!gap) begin
      @(negedge clk);
      in_valid   = 1'b0;
      in_samples = '0;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_samples = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1200000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0]        prev_sel;
    logic [NCH*SW-1:0] smp;
    rst = 1'b1; in_valid = 1'b0; in_samples = '0; ch_en = 4'hF;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 sel", sel_ch, 0);
    check("R9 out_valid", out_valid, 0);
    check("R9 out_samples", out_samples, 0);
    rst = 1'b0;
    @(negedge clk);

    prev_sel = 2'd0;
    for (int v = 0; v < NV; v++) begin
      smp = {TV[v].s3, TV[v].s2, TV[v].s1, TV[v].s0};
      for (int f = 0; f < int'(TV[v].nf); f++) begin
        run_frame(smp, TV[v].en, 1'b0);
        // R7 R8: last sample of the frame uses the selection that held during it
        check("R7 out_valid", out_valid, 1);
        check_bcast("R8 broadcast", smp[prev_sel*SW +: SW]);
      end
      check($sformatf("R3/R4 sel after row %0d", v), sel_ch, TV[v].exp_sel);
      @(negedge clk);
      check("R7 valid drops", out_valid, 0);
      prev_sel = TV[v].exp_sel;
    end

    // R9: mid-stream reset clears counters and selection
    do_reset();
    check("R9 sel after reset", sel_ch, 0);
    check("R9 out_valid after reset", out_valid, 0);

    // R1: idle beats between samples neither add nor advance; ch3 would have switched early otherwise
    smp = {16'd300, 16'd5, 16'd5, 16'd5};
    for (int f = 0; f < 9; f++) run_frame(smp, 4'hF, 1'b1);
    check("R1 gaps, 9 frames", sel_ch, 0);
    check_bcast("R7 broadcast ch0", 16'd5);
    run_frame(smp, 4'hF, 1'b1);
    check("R1 gaps, 10th frame", sel_ch, 3);

    // R6: empty mask leaves everything unchanged
    smp = {16'd5, 16'd5, 16'd5, 16'd900};
    for (int f = 0; f < 10; f++) run_frame(smp, 4'h0, 1'b0);
    check("R6 empty mask", sel_ch, 3);
    check_bcast("R8 broadcast ch3", 16'd5);
    // R3: ch0 counter starts from zero, switches only at the tenth win
    for (int f = 0; f < 9; f++) run_frame(smp, 4'hF, 1'b0);
    check("R3 ch0 9 wins", sel_ch, 3);
    run_frame(smp, 4'hF, 1'b0);
    check("R4 ch0 10 wins", sel_ch, 0);
    check_bcast("R8 old sel on last sample", 16'd5);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule